// File: doc/BRIEF.md
# Synchronous On-Die Termination Controller

This block is the device-side model of how a DDR3-style memory switches its nominal termination in synchronous mode. On every rising clock edge it takes a sample of the termination-request input. The sample is delayed through a shift register, and the delay is chosen from the programmed write latency, which is the additive latency plus the CAS write latency. The delayed value drives the termination-enable output. The same latency applies when termination turns on and when it turns off.

The block also checks how long the request is held. Each time the request is first registered high, a short minimum hold window opens. A write command registered while the request is high opens a window measured from that command, and its length depends on the burst-length select. If the request is registered low before the open window has run out, a sticky violation flag is set. Synchronous termination only works while the delay-locked loop reports lock. While it does not, every sample counts as low, the hold windows are cleared and the termination output is off.

Top module: `odt_sync_term`

## Requirements
- R1: Take the write latency as WL = add_lat + cas_wr_lat. If `term_req` is registered high at clock edge E after a run of low samples, `rtt_on` rises right after edge E + (WL - 2) and not before, provided the settings stay fixed.
- R2: If `term_req` is registered low at edge E after a run of high samples, `rtt_on` falls right after edge E + (WL - 2), using the same WL as R1.
- R3: If WL is 2 or less, the latency is 0, so `rtt_on` follows the most recent registered sample. If WL - 2 is greater than MAX_WL - 2, the latency is clamped to MAX_WL - 2.
- R4: The termination strength code `rtt_sel` (3 bits) value 000 means termination is disabled, and `rtt_on` then stays 0. `rtt_sel_eff` equals `rtt_sel` while `rtt_on` is 1 and equals 000 otherwise.
- R5: A write (`wr_cmd` = 1) registered together with `term_req` = 1 requires the request to stay high until at least HOLD_SHORT edges (4, when `burst8` = 0) or HOLD_LONG edges (6, when `burst8` = 1) after that write's edge. A low registered earlier sets `hold_viol`. If a window is already open, the later of the two end points applies.
- R6: Once `term_req` is registered high, it must stay high for at least HOLD_SHORT (4) edges. A low registered at edge E + n with n < 4 sets `hold_viol` right after that edge.
- R7: `hold_viol` stays set until reset.
- R8: While `dll_locked` = 0, each sample counts as low, `rtt_on` = 0, `rtt_sel_eff` = 000, any open hold window is discarded, and no violation is flagged.
- R9: A synchronous active-high `rst` clears the latency pipeline, the hold window and `hold_viol` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; sampling happens on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| term_req | input | 1 | Termination request from the controller |
| wr_cmd | input | 1 | Write command strobe, one cycle per command |
| burst8 | input | 1 | 1 = burst of 8, 0 = burst of 4 |
| add_lat | input | AL_W | Additive latency in clocks |
| cas_wr_lat | input | CWL_W | CAS write latency in clocks |
| dll_locked | input | 1 | Delay-locked loop is locked |
| rtt_sel | input | 3 | Nominal termination strength code |
| rtt_on | output | 1 | Termination enabled |
| rtt_sel_eff | output | 3 | Strength code currently applied |
| hold_viol | output | 1 | Sticky hold-time violation flag |

## Verification
`rtt_on` changes WL - 2 edges after the edge that registers a change in the request. `hold_viol` changes right after the edge that registers the early low. `rtt_on` and `rtt_sel_eff` also respond within the same cycle to `dll_locked`, `rtt_sel` and the latency settings. The bench therefore drives inputs on the falling edge and compares outputs 1 time unit later. The expected values come from a history of effective samples indexed by the clamped latency, together with a deadline edge number for the hold windows. Both are advanced once per rising edge, so every expected value lines up with the edge that produced it. Directed runs cover the latency boundaries, a disabled strength code, burst-of-4 and burst-of-8 write windows, early release, loss of lock and reset. Seeded random traffic then mixes all of these.

// File: rtl/odt_sync_term.sv
module odt_sync_term #(
  parameter int AL_W       = 4,
  parameter int CWL_W      = 4,
  parameter int MAX_WL     = 24,
  parameter int HOLD_SHORT = 4,
  parameter int HOLD_LONG  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             term_req,
  input  logic             wr_cmd,
  input  logic             burst8,
  input  logic [AL_W-1:0]  add_lat,
  input  logic [CWL_W-1:0] cas_wr_lat,
  input  logic             dll_locked,
  input  logic [2:0]       rtt_sel,
  output logic             rtt_on,
  output logic [2:0]       rtt_sel_eff,
  output logic             hold_viol
);
  localparam int DEPTH = MAX_WL - 1;
  localparam int TAP_W = $clog2(DEPTH);
  localparam int REM_W = $clog2(HOLD_LONG + 1);

  logic [DEPTH-1:0] pipe;
  logic [TAP_W-1:0] tap;
  logic [REM_W-1:0] rem, rem_nxt, rem_dec, wr_win;
  logic             sample, early;

  // latency tap from AL + CWL - 2, clamped to the pipeline
  always_comb begin
    int lat;
    lat = int'(add_lat) + int'(cas_wr_lat) - 2;
    if (lat < 0) lat = 0;
    if (lat > DEPTH - 1) lat = DEPTH - 1;
    tap = TAP_W'(lat);
  end

  assign sample = term_req & dll_locked;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[DEPTH-2:0], sample};
  end

  assign rtt_on      = dll_locked & (|rtt_sel) & pipe[tap];
  assign rtt_sel_eff = rtt_on ? rtt_sel : 3'b000;

  // hold window tracking
  assign wr_win  = burst8 ? REM_W'(HOLD_LONG - 1) : REM_W'(HOLD_SHORT - 1);
  assign rem_dec = (rem == '0) ? '0 : rem - 1'b1;
  assign early   = dll_locked & pipe[0] & ~term_req & (rem != '0);

  always_comb begin
    if (!sample) rem_nxt = '0;
    else begin
      rem_nxt = pipe[0] ? rem_dec : REM_W'(HOLD_SHORT - 1);
      if (wr_cmd && rem_nxt < wr_win) rem_nxt = wr_win;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem       <= '0;
      hold_viol <= 1'b0;
    end else begin
      rem <= rem_nxt;
      if (early) hold_viol <= 1'b1;
    end
  end

  p_reset_clears_r9: assert property (@(posedge clk)
    rst |=> (pipe == '0) && !hold_viol && (rem == '0));

  p_viol_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    hold_viol |=> hold_viol);

  p_viol_on_release_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_viol) |-> ($past(pipe[0]) && !pipe[0]));

  p_dll_off_clears_r8: assert property (@(posedge clk) disable iff (rst)
    !dll_locked |=> (!pipe[0] && rem == '0));

  p_bl8_window_r5: assert property (@(posedge clk) disable iff (rst)
    (dll_locked && term_req && wr_cmd && burst8) |=> (rem == REM_W'(HOLD_LONG - 1)));
endmodule

// File: tb/test_odt_sync_term.sv
module test_odt_sync_term;
  localparam int CLK_P  = 10;
  localparam int MAX_WL = 24;

  logic clk = 1'b0;
  logic rst, term_req, wr_cmd, burst8, dll_locked;
  logic [3:0] add_lat, cas_wr_lat;
  logic [2:0] rtt_sel;
  logic rtt_on, hold_viol;
  logic [2:0] rtt_sel_eff;

  int checks = 0, errors = 0;
  bit hist [0:63];
  int edge_n = 0, deadline = 0;
  bit m_prev = 0, m_viol = 0;

  always #(CLK_P/2) clk = ~clk;

  odt_sync_term i_odt_sync_term (
    .clk(clk), .rst(rst), .term_req(term_req), .wr_cmd(wr_cmd), .burst8(burst8),
    .add_lat(add_lat), .cas_wr_lat(cas_wr_lat), .dll_locked(dll_locked),
    .rtt_sel(rtt_sel), .rtt_on(rtt_on), .rtt_sel_eff(rtt_sel_eff), .hold_viol(hold_viol));

  function automatic int exp_lat(int al, int cwl);
    int l = al + cwl - 2;
    if (l < 0) l = 0;
    if (l > MAX_WL - 2) l = MAX_WL - 2;
    return l;
  endfunction

  function automatic bit exp_rtt();
    return dll_locked && (rtt_sel != 3'b000) && hist[exp_lat(int'(add_lat), int'(cas_wr_lat))];
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at edge %0d: actual %0d expected %0d", tag, edge_n, act, exp);
    end
  endtask

  task automatic model_edge();
    bit s;
    if (rst) begin
      foreach (hist[k]) hist[k] = 1'b0;
      m_viol = 0; m_prev = 0; deadline = 0;
      return;
    end
    s = term_req && dll_locked;
    for (int k = 63; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = s;
    edge_n++;
    if (dll_locked) begin
      if (!s && m_prev && edge_n < deadline) m_viol = 1;
      if (s && !m_prev) deadline = edge_n + 4;
      if (s && wr_cmd && deadline < edge_n + (burst8 ? 6 : 4)) deadline = edge_n + (burst8 ? 6 : 4);
    end
    m_prev = s;
  endtask

  task automatic cyc(string tag);
    bit e;
    #1;
    e = exp_rtt();
    chk({tag, " rtt_on"}, rtt_on, e);
    chk({tag, " rtt_sel_eff"}, rtt_sel_eff, e ? rtt_sel : 3'b000);
    chk({tag, " hold_viol"}, hold_viol, m_viol);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    wr_cmd = 1'b0;
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1; term_req = 1'b0; wr_cmd = 1'b0;
    run(2, "R9");
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; term_req = 0; wr_cmd = 0; burst8 = 0; dll_locked = 1;
    add_lat = 4'd0; cas_wr_lat = 4'd5; rtt_sel = 3'b010;
    @(negedge clk);
    run(3, "R9");
    rst = 1'b0;
    chk("R9 reset rtt_on", rtt_on, 0);
    chk("R9 reset hold_viol", hold_viol, 0);

    // R1/R2: WL = 2 + 5, latency 5
    add_lat = 4'd2; cas_wr_lat = 4'd5;
    term_req = 1; run(8, "R1");
    term_req = 0; run(10, "R2");

    // R3: small and clamped latency
    add_lat = 4'd0; cas_wr_lat = 4'd1;
    term_req = 1; run(5, "R3");
    term_req = 0; run(3, "R3");
    add_lat = 4'd15; cas_wr_lat = 4'd15;
    term_req = 1; run(26, "R3");
    term_req = 0; run(26, "R3");

    // R4: strength code 000 disables
    add_lat = 4'd0; cas_wr_lat = 4'd4;
    rtt_sel = 3'b000; term_req = 1; run(6, "R4");
    rtt_sel = 3'b101; run(2, "R4");
    term_req = 0; run(6, "R4");

    // R5: BL8 write window violated, then BL4 window honoured
    do_reset();
    term_req = 1; run(2, "R5");
    wr_cmd = 1; burst8 = 1; run(5, "R5");
    term_req = 0; run(2, "R5");
    chk("R5 bl8 early release flagged", hold_viol, 1);
    do_reset();
    term_req = 1; run(2, "R5");
    wr_cmd = 1; burst8 = 0; run(4, "R5");
    term_req = 0; run(2, "R5");
    chk("R5 bl4 window met", hold_viol, 0);

    // R6/R7: short pulse then stickiness
    term_req = 1; run(2, "R6");
    term_req = 0; run(1, "R6");
    chk("R6 short pulse flagged", hold_viol, 1);
    run(20, "R7");
    chk("R7 flag kept", hold_viol, 1);

    // R8: lost lock
    do_reset();
    term_req = 1; run(8, "R8");
    dll_locked = 0; run(1, "R8");
    chk("R8 rtt off when unlocked", rtt_on, 0);
    term_req = 0; run(1, "R8");
    term_req = 1; run(1, "R8");
    term_req = 0; run(6, "R8");
    chk("R8 no violation when unlocked", hold_viol, 0);
    dll_locked = 1; run(4, "R8");

    // seeded random traffic
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 39) == 0) begin
        add_lat = 4'($urandom_range(0, 15)); cas_wr_lat = 4'($urandom_range(0, 15));
      end
      if ($urandom_range(0, 49) == 0) rtt_sel = 3'($urandom_range(0, 7));
      rst        = ($urandom_range(0, 149) == 0);
      dll_locked = ($urandom_range(0, 29) != 0);
      if ($urandom_range(0, 5) == 0) term_req = ~term_req;
      wr_cmd = ($urandom_range(0, 4) == 0);
      burst8 = 1'($urandom_range(0, 1));
      cyc("R1 R2 R5 R6 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule